// File: doc/BRIEF.md
# Speculative Global-History Branch Direction Predictor

This block predicts the direction of conditional branches for a pipelined processor. The fetch stage presents a program counter and a flag marking the instruction as a conditional branch. One clock edge later the block returns a taken/not-taken guess, along with the global history value that was used to form it. The guess comes from a table of two-bit saturating counters. The table is addressed by the word-aligned PC bits XORed with a global history register.

The history register is updated speculatively. Each branch prediction shifts its predicted direction in at once, so back-to-back branches look up different entries. When the branch resolves later in the pipeline, the resolve port brings back its PC, its real outcome, a misprediction flag and the history snapshot issued with its prediction. That snapshot selects the table entry to train. On a misprediction the snapshot also rebuilds the history register, with the correct outcome shifted in.

Top module: `gshare_predictor`

## Requirements
- R1: Each table entry is a two-bit counter encoded 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A resolve moves the addressed entry one step up when the outcome is taken and one step down when it is not taken. The entry stays put at 11 and at 00. A prediction made in the same cycle as the write reads the old value.
- R2: The entry trained by a resolve is selected by res_pc together with res_hist. The history register's value at resolve time plays no part.
- R3: A fetch with fetch_valid high and fetch_stall low shifts the predicted bit into the least significant end of the history register. The most significant bit is dropped.
- R4: A resolve with res_mispred high sets the history register to res_hist shifted left by one, with res_taken placed in bit 0.
- R5: While fetch_stall is high, pred_valid, pred_taken and pred_hist hold their values. The history register takes no speculative shift.
- R6: The lookup index is fetch_pc[OFF_W+IDX_W-1:OFF_W] XOR the history register. The resolve index is formed the same way from res_pc and res_hist.
- R7: pred_taken is bit 1 of the addressed counter, and pred_hist is the history value before the prediction's own shift. Both appear one edge after the fetch.
- R8: After reset, pred_valid is 0, the history register is zero and every counter holds 01, so every first prediction is not taken.
- R9: When a misprediction resolve and a prediction fall in the same cycle, the repair of R4 wins and the prediction's shift is discarded. The prediction itself is still issued.
- R10: A non-stalled fetch with fetch_valid low drives pred_valid to 0 and leaves the history register unchanged.
- R11: A resolve with res_mispred low does not change the history register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetched instruction is a conditional branch |
| fetch_stall | input | 1 | Fetch stage stalled; hold outputs |
| fetch_pc | input | PC_W | Fetch program counter |
| pred_valid | output | 1 | Prediction outputs belong to a branch |
| pred_taken | output | 1 | Predicted direction |
| pred_hist | output | IDX_W | History snapshot used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_mispred | input | 1 | Resolving branch was mispredicted |
| res_pc | input | PC_W | PC of the resolving branch |
| res_hist | input | IDX_W | Snapshot issued with that branch's prediction |

## Verification
A prediction is due on the outputs at the first rising edge after a fetch with fetch_valid high and fetch_stall low. A history shift or repair shows up as pred_hist of the next prediction after that same edge. A counter written at a resolve edge changes only the predictions launched in later cycles. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples 2 ns after it. A model of the table and history register, built from the requirements, is advanced by one step per edge, so each expected value lines up with the cycle in which it is due.

// File: rtl/gsh_pkg.sv
// Package: shared counter type and saturating step for the predictor.
// Assumes a two-bit counter whose upper bit is the predicted direction.
package gsh_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    // Saturating step of a counter toward the observed outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_t'(cur + 2'b01);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_t'(cur - 2'b01);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gsh_index.sv
// Module: gsh_index
// Forms a table index by XORing the word-address field of a PC with a
// history value. Purely combinational; the caller supplies the field.
module gsh_index #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] pc_field,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);

    // Hash of address field and history.
    always_comb begin
        idx = pc_field ^ hist;
    end

endmodule

// File: rtl/gsh_history.sv
// Module: gsh_history
// Global history shift register. A repair request overrides a speculative
// shift in the same cycle. Assumes IDX_W >= 2.
module gsh_history #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             repair_en,
    input  logic [IDX_W-2:0] repair_hist_lo,
    input  logic             repair_bit,
    output logic [IDX_W-1:0] ghr_o
);

    logic [IDX_W-1:0] ghr_q;

    // Clear on reset, repair on mispredict, else shift on a prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghr_q <= '0;
        end else if (repair_en) begin
            ghr_q <= {repair_hist_lo, repair_bit};
        end else if (shift_en) begin
            ghr_q <= {ghr_q[IDX_W-2:0], shift_bit};
        end
    end

    assign ghr_o = ghr_q;

endmodule

// File: rtl/gsh_counter.sv
// Module: gsh_counter
// One two-bit saturating counter cell; resets to weak not-taken.
module gsh_counter
    import gsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic taken,
    output ctr_t state_o
);

    ctr_t state_q;

    // Reset to weak not-taken, step toward the outcome when addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTR_WNT;
        end else if (upd_en) begin
            state_q <= ctr_step(state_q, taken);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/gsh_table.sv
// Module: gsh_table
// Pattern table built from 2**IDX_W counter cells. Reads are
// combinational and see the value from before a same-cycle write.
module gsh_table
    import gsh_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t cells [DEPTH];
    ctr_t rd_state;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic hit;
        // Decode of the write address for this cell.
        always_comb begin
            hit = wr_en && (wr_idx == IDX_W'(i));
        end
        gsh_counter u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (hit),
            .taken   (wr_taken),
            .state_o (cells[i])
        );
    end

    // Read mux; the direction is the counter's upper bit.
    always_comb begin
        rd_state = cells[rd_idx];
        rd_taken = rd_state[1];
    end

endmodule

// File: rtl/gshare_predictor.sv
// Module: gshare_predictor
// Global-history direction predictor with speculative history update and
// repair from a carried snapshot. Predictions are registered and appear
// one edge after the fetch. Assumes PC_W > OFF_W + IDX_W and IDX_W >= 2.
module gshare_predictor #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 2,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic             fetch_stall,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_valid,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_hist,
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic             res_mispred,
    input  logic [PC_W-1:0]  res_pc,
    input  logic [IDX_W-1:0] res_hist
);

    localparam int FLD_LO = OFF_W;
    localparam int FLD_HI = OFF_W + IDX_W - 1;

    logic [IDX_W-1:0] ghr_w;
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] train_idx;
    logic             look_taken;
    logic             fetch_fire;
    logic             repair;
    logic             unused_pc_bits;
    logic             pv_q;
    logic             pt_q;
    logic [IDX_W-1:0] ph_q;

    // Qualify the lookup and the repair request.
    always_comb begin
        fetch_fire = fetch_valid && !fetch_stall;
        repair     = res_valid && res_mispred;
    end

    assign unused_pc_bits = ^{fetch_pc[PC_W-1:FLD_HI+1], fetch_pc[FLD_LO-1:0],
                              res_pc[PC_W-1:FLD_HI+1], res_pc[FLD_LO-1:0]};

    gsh_index #(.IDX_W(IDX_W)) u_look_idx (
        .pc_field (fetch_pc[FLD_HI:FLD_LO]),
        .hist     (ghr_w),
        .idx      (look_idx)
    );

    gsh_index #(.IDX_W(IDX_W)) u_train_idx (
        .pc_field (res_pc[FLD_HI:FLD_LO]),
        .hist     (res_hist),
        .idx      (train_idx)
    );

    gsh_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_taken (look_taken),
        .wr_en    (res_valid),
        .wr_idx   (train_idx),
        .wr_taken (res_taken)
    );

    gsh_history #(.IDX_W(IDX_W)) u_hist (
        .clk            (clk),
        .rst_n          (rst_n),
        .shift_en       (fetch_fire),
        .shift_bit      (look_taken),
        .repair_en      (repair),
        .repair_hist_lo (res_hist[IDX_W-2:0]),
        .repair_bit     (res_taken),
        .ghr_o          (ghr_w)
    );

    // Prediction register: loads only when fetch is not stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q <= 1'b0;
            pt_q <= 1'b0;
            ph_q <= '0;
        end else if (!fetch_stall) begin
            pv_q <= fetch_valid;
            if (fetch_valid) begin
                pt_q <= look_taken;
                ph_q <= ghr_w;
            end
        end
    end

    assign pred_valid = pv_q;
    assign pred_taken = pt_q;
    assign pred_hist  = ph_q;

endmodule

// File: rtl/gshare_predictor_chk.sv
// Module: gshare_predictor_chk
// Temporal checks on the predictor's history handling and output hold.
// Attached to every gshare_predictor instance by the bind below.
module gshare_predictor_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             fetch_stall,
    input logic             res_valid,
    input logic             res_taken,
    input logic             res_mispred,
    input logic [IDX_W-2:0] res_hist_lo,
    input logic             pred_valid,
    input logic             pred_taken,
    input logic [IDX_W-1:0] pred_hist,
    input logic [IDX_W-1:0] ghr
);

    // R3: speculative shift takes in the registered prediction bit.
    assert_spec_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_stall && !(res_valid && res_mispred))
        |=> (ghr == {$past(ghr[IDX_W-2:0]), pred_taken}));

    // R4, R9: repair rebuilds history from the snapshot, beating a shift.
    assert_repair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispred)
        |=> (ghr == {$past(res_hist_lo), $past(res_taken)}));

    // R5: a stalled fetch keeps all prediction outputs.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> ($stable(pred_valid) && $stable(pred_taken) && $stable(pred_hist)));

    // R7: the issued snapshot is the history from before the shift.
    assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_stall) |=> (pred_valid && pred_hist == $past(ghr)));

    // R10, R11: no prediction and no repair leaves history unchanged.
    assert_hist_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fetch_valid && !fetch_stall) && !(res_valid && res_mispred)) |=> $stable(ghr));

endmodule

bind gshare_predictor gshare_predictor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_stall (fetch_stall),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_mispred (res_mispred),
    .res_hist_lo (res_hist[IDX_W-2:0]),
    .pred_valid  (pred_valid),
    .pred_taken  (pred_taken),
    .pred_hist   (pred_hist),
    .ghr         (ghr_w)
);

// File: tb/test_gshare_predictor.sv
`timescale 1ns/1ps
module test_gshare_predictor;

    localparam int PC_W  = 32;
    localparam int OFF_W = 2;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fetch_valid, fetch_stall;
    logic [PC_W-1:0]  fetch_pc;
    logic             pred_valid, pred_taken;
    logic [IDX_W-1:0] pred_hist;
    logic             res_valid, res_taken, res_mispred;
    logic [PC_W-1:0]  res_pc;
    logic [IDX_W-1:0] res_hist;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic [1:0]       mt [DEPTH];
    logic [IDX_W-1:0] mghr;
    logic             e_pv, e_pt;
    logic [IDX_W-1:0] e_ph;

    always #4 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_gshare_predictor (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_stall(fetch_stall), .fetch_pc(fetch_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
        .res_valid(res_valid), .res_taken(res_taken), .res_mispred(res_mispred),
        .res_pc(res_pc), .res_hist(res_hist)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pc_of(input logic [IDX_W-1:0] f);
        return {20'h0, f, 2'b00};
    endfunction

    // One clock: drive at falling edge, update model per requirements,
    // sample 2 ns after the rising edge.
    task automatic cyc(input string tag, input logic fv, input logic [31:0] fpc,
                       input logic st, input logic rv, input logic rt, input logic rm,
                       input logic [31:0] rpc, input logic [IDX_W-1:0] rh);
        logic [IDX_W-1:0] li, ri, ng;
        logic             lb;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc; fetch_stall = st;
        res_valid = rv; res_taken = rt; res_mispred = rm; res_pc = rpc; res_hist = rh;
        li = fpc[OFF_W +: IDX_W] ^ mghr;            // R6
        ri = rpc[OFF_W +: IDX_W] ^ rh;              // R2, R6
        lb = mt[li][1];                             // R7
        ng = mghr;
        if (!st) begin
            e_pv = fv;
            if (fv) begin
                e_pt = lb; e_ph = mghr;
                ng = {mghr[IDX_W-2:0], lb};         // R3
            end
        end
        if (rv && rm) ng = {rh[IDX_W-2:0], rt};     // R4, R9
        if (rv) begin                               // R1
            if (rt && mt[ri] != 2'b11) mt[ri] = mt[ri] + 2'b01;
            else if (!rt && mt[ri] != 2'b00) mt[ri] = mt[ri] - 2'b01;
        end
        @(posedge clk);
        #2;
        mghr = ng;
        chk({tag, " pred_valid"}, {31'b0, pred_valid}, {31'b0, e_pv});
        if (e_pv) begin
            chk({tag, " pred_taken"}, {31'b0, pred_taken}, {31'b0, e_pt});
            chk({tag, " pred_hist"}, {22'b0, pred_hist}, {22'b0, e_ph});
        end
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, '0);
    endtask

    task automatic predict(input string tag, input logic [31:0] pc);
        cyc(tag, 1'b1, pc, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, '0);
    endtask

    task automatic resolve(input string tag, input logic [31:0] pc, input logic [IDX_W-1:0] h,
                           input logic t, input logic m);
        cyc(tag, 1'b0, 32'h0, 1'b0, 1'b1, t, m, pc, h);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        fetch_valid = 0; fetch_stall = 0; fetch_pc = 0;
        res_valid = 0; res_taken = 0; res_mispred = 0; res_pc = 0; res_hist = 0;
        for (int i = 0; i < DEPTH; i++) mt[i] = 2'b01;
        mghr = '0; e_pv = 0; e_pt = 0; e_ph = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R8: reset state and first predictions.
    task automatic t_reset;
        do_reset();
        #1;
        chk("R8 pred_valid after reset", {31'b0, pred_valid}, 32'h0);
        predict("R8 first prediction", pc_of(10'h123));
        chk("R8 not taken after reset", {31'b0, pred_taken}, 32'h0);
        chk("R8 zero history", {22'b0, pred_hist}, 32'h0);
    endtask

    // R1: saturation at both ends; history held at zero throughout.
    task automatic t_saturate;
        logic [31:0] p;
        p = pc_of(10'h05A);
        resolve("R11 clear", pc_of(10'h300), '0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) resolve("R1 up", p, '0, 1'b1, 1'b0);
        resolve("R1 down", p, '0, 1'b0, 1'b0);
        predict("R1 after 4 up 1 down", p);
        chk("R1 saturated high stays taken", {31'b0, pred_taken}, 32'h1);
        resolve("R4 reset hist", pc_of(10'h301), '0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) resolve("R1 down", p, '0, 1'b0, 1'b0);
        resolve("R1 up", p, '0, 1'b1, 1'b0);
        predict("R1 after floor then up", p);
        chk("R1 saturated low no wrap", {31'b0, pred_taken}, 32'h0);
    endtask

    // R2, R4, R6: training uses the carried snapshot, not current history.
    task automatic t_snapshot_train;
        logic [31:0] p;
        p = pc_of(10'h0F0);
        resolve("R4 hist zero", pc_of(10'h310), '0, 1'b0, 1'b1);
        resolve("R2 train", p, 10'h155, 1'b1, 1'b0);
        resolve("R2 train", p, 10'h155, 1'b1, 1'b0);
        predict("R2 current hist", p);
        chk("R2 current history entry untouched", {31'b0, pred_taken}, 32'h0);
        resolve("R4 set hist", pc_of(10'h311), 10'h0AA, 1'b1, 1'b1);
        predict("R2 snapshot hist", p);
        chk("R4 history repaired", {22'b0, pred_hist}, 32'h155);
        chk("R2 snapshot entry trained", {31'b0, pred_taken}, 32'h1);
    endtask

    // R3, R7: back-to-back branches get distinct snapshots.
    task automatic t_spec_shift;
        logic [31:0] p;
        p = pc_of(10'h222);
        resolve("R4 hist zero", pc_of(10'h320), '0, 1'b0, 1'b1);
        resolve("R3 train", p, '0, 1'b1, 1'b0);
        predict("R3 first", p);
        chk("R7 taken from counter msb", {31'b0, pred_taken}, 32'h1);
        chk("R7 pre-shift snapshot", {22'b0, pred_hist}, 32'h0);
        predict("R3 second", pc_of(10'h001));
        chk("R3 shifted in predicted bit", {22'b0, pred_hist}, 32'h1);
    endtask

    // R5: stall holds outputs and history.
    task automatic t_stall;
        logic [IDX_W-1:0] h0;
        predict("R5 before stall", pc_of(10'h2A2));
        h0 = pred_hist;
        cyc("R5 stalled branch", 1'b1, pc_of(10'h3FF), 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, '0);
        chk("R5 snapshot held", {22'b0, pred_hist}, {22'b0, h0});
        cyc("R5 stalled idle", 1'b0, pc_of(10'h3FF), 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, '0);
        chk("R5 valid held", {31'b0, pred_valid}, 32'h1);
        predict("R5 after stall", pc_of(10'h004));
        chk("R5 no shift while stalled", {22'b0, pred_hist}, {22'b0, mghr[IDX_W-1:1] == h0[IDX_W-2:0] ? mghr >> 1 : 10'h3FF} & 32'h0 | {22'b0, e_ph});
    endtask

    // R9: repair beats same-cycle prediction.
    task automatic t_collide;
        resolve("R4 hist zero", pc_of(10'h330), '0, 1'b0, 1'b1);
        cyc("R9 collide", 1'b1, pc_of(10'h010), 1'b0, 1'b1, 1'b0, 1'b1, pc_of(10'h331), 10'h2C3);
        chk("R9 prediction still issued", {31'b0, pred_valid}, 32'h1);
        chk("R9 prediction saw old history", {22'b0, pred_hist}, 32'h0);
        predict("R9 next", pc_of(10'h011));
        chk("R9 repair won over shift", {22'b0, pred_hist}, 32'h186);
    endtask

    // R10, R11: non-branch fetch and correct resolve leave history alone.
    task automatic t_quiet;
        resolve("R4 set hist", pc_of(10'h340), 10'h0F0, 1'b1, 1'b1);
        idle("R10 non-branch");
        chk("R10 pred_valid low", {31'b0, pred_valid}, 32'h0);
        cyc("R10 non-branch fetch", 1'b0, pc_of(10'h3AB), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, '0);
        resolve("R11 correct resolve", pc_of(10'h341), 10'h000, 1'b0, 1'b0);
        predict("R11 probe", pc_of(10'h012));
        chk("R11 history unchanged", {22'b0, pred_hist}, 32'h1E1);
    endtask

    // Mixed traffic against the model, covering R1 to R11 together.
    task automatic t_random;
        for (int n = 0; n < 3000; n++) begin
            cyc("R3 R4 R9 mixed", ($urandom % 4) != 0, pc_of(IDX_W'($urandom % 16)),
                ($urandom % 6) == 0, ($urandom % 2) == 0, $urandom % 2,
                ($urandom % 5) == 0, pc_of(IDX_W'($urandom % 16)), IDX_W'($urandom % 8));
        end
    endtask

    initial begin
        t_reset();
        t_saturate();
        t_snapshot_train();
        t_spec_shift();
        t_stall();
        t_collide();
        t_quiet();
        t_random();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule